// File: doc/BRIEF.md
# Bang-Bang Duty Integrator

This block closes a low-resolution voltage loop around a one-bit decision. A prescaler divides the system clock into sample ticks. On each tick the block raises an evaluate strobe to an external clocked comparator. It waits a programmable settling time and then reads the comparator's single-bit verdict. It then moves a 10-bit duty word one LSB toward the reference. The duty word is the command for a downstream PWM stage. The counter is the loop's only integrator.

Loop gain scales with the tick rate divided by the duty quantum. Software therefore tunes the transient response and the limit-cycle amplitude only through the prescale value. The settling window is set independently, so that a slow comparator can be given enough time. The starting duty word comes from a separate input and is taken while reset is held.

Top module: `bb_duty_loop`

## Requirements
- R1: While `rst` is high (synchronous, active high), `duty` is loaded from `init_duty` and `cmp_eval` is low. Both are visible on the first falling clock after reset.
- R2: While `loop_en` is low, no evaluate strobe starts and `duty` holds its value, whatever `cmp_low` does.
- R3: With `loop_en` high, the prescaler issues a sample tick every `prescale`+1 clock cycles. When `settle_cyc` < `prescale`, successive `cmp_eval` rising edges are exactly `prescale`+1 cycles apart.
- R4: Each evaluate strobe stays high for exactly `settle_cyc`+1 clock cycles.
- R5: The comparator verdict is taken only on the last high cycle of the strobe. `duty` changes on the same edge at which `cmp_eval` falls, and at no other time.
- R6: The encoding is `cmp_low` = 1 for sensed output below reference, and `cmp_low` = 0 for above. A verdict of 1 adds one LSB to `duty`, and a verdict of 0 subtracts one LSB. Exactly one step is made per strobe.
- R7: `duty` saturates: an up step at 1023 leaves it at 1023, and a down step at 0 leaves it at 0.
- R8: A tick that arrives while a strobe is open is discarded, not queued. With `prescale`=2 and `settle_cyc`=5, strobes start 9 cycles apart, and each strobe still makes one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; loads the duty word |
| loop_en | input | 1 | Enables sample ticks |
| prescale | input | 12 | Tick period minus one, in clock cycles |
| settle_cyc | input | 6 | Strobe length minus one, in clock cycles |
| init_duty | input | 10 | Duty word taken during reset |
| cmp_low | input | 1 | Comparator verdict: 1 = output below reference |
| cmp_eval | output | 1 | Evaluate strobe to the comparator |
| duty | output | 10 | Duty command to the PWM stage |

## Verification
The hardest case to reach is a tick landing inside an open strobe, which only happens when the settling window is at least as long as the tick period. The bench creates it with a short prescale and a long settle time. It then measures the rise-to-rise spacing of the strobe and confirms that each strobe still produces a single step. A second awkward point is the exact sampling cycle. The bench drives the verdict one way for all but the final strobe cycle and the other way in that final cycle, and the direction of the step reveals which cycle was used.

// File: rtl/bbl_pkg.sv
package bbl_pkg;

    localparam int DUTY_W_DEF = 10;
    localparam int PRE_W_DEF  = 12;
    localparam int SET_W_DEF  = 6;

    typedef enum logic {
        STEP_DN = 1'b0,
        STEP_UP = 1'b1
    } step_dir_e;

    typedef struct packed {
        logic      valid;
        step_dir_e dir;
    } step_t;

    function automatic step_dir_e dir_of(input logic below_ref);
        return below_ref ? STEP_UP : STEP_DN;
    endfunction

endpackage

// File: rtl/bb_tick_gen.sv
module bb_tick_gen #(
    parameter int PRE_W = bbl_pkg::PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic             wrap;

    assign wrap = (pcnt == prescale);
    assign tick = en && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt <= '0;
        end else if (wrap) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/bb_sample_seq.sv
module bb_sample_seq
    import bbl_pkg::*;
#(
    parameter int SET_W = bbl_pkg::SET_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [SET_W-1:0] settle_cyc,
    input  logic             cmp_low,
    output logic             eval,
    output step_t            step
);
    logic             busy;
    logic [SET_W-1:0] scnt;
    logic             last;

    assign last = busy && (scnt == settle_cyc);
    assign eval = busy;

    always_comb begin
        step.valid = last;
        step.dir   = dir_of(cmp_low);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            scnt <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                scnt <= scnt + SET_W'(1);
            end
        end else if (tick) begin
            busy <= 1'b1;
            scnt <= '0;
        end
    end
endmodule

// File: rtl/bb_sat_counter.sv
module bb_sat_counter
    import bbl_pkg::*;
#(
    parameter int DUTY_W = bbl_pkg::DUTY_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] init_val,
    input  step_t             step,
    output logic [DUTY_W-1:0] value
);
    localparam logic [DUTY_W-1:0] TOP = '1;
    localparam logic [DUTY_W-1:0] BOT = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= init_val;
        end else if (step.valid) begin
            if (step.dir == STEP_UP && value != TOP) begin
                value <= value + DUTY_W'(1);
            end else if (step.dir == STEP_DN && value != BOT) begin
                value <= value - DUTY_W'(1);
            end
        end
    end
endmodule

// File: rtl/bb_duty_loop.sv
module bb_duty_loop
    import bbl_pkg::*;
#(
    parameter int DUTY_W = bbl_pkg::DUTY_W_DEF,
    parameter int PRE_W  = bbl_pkg::PRE_W_DEF,
    parameter int SET_W  = bbl_pkg::SET_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_en,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [SET_W-1:0]  settle_cyc,
    input  logic [DUTY_W-1:0] init_duty,
    input  logic              cmp_low,
    output logic              cmp_eval,
    output logic [DUTY_W-1:0] duty
);
    logic  tick;
    step_t step;

    bb_tick_gen #(.PRE_W(PRE_W)) i_tick (
        .clk      (clk),
        .rst      (rst),
        .en       (loop_en),
        .prescale (prescale),
        .tick     (tick)
    );

    bb_sample_seq #(.SET_W(SET_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .settle_cyc (settle_cyc),
        .cmp_low    (cmp_low),
        .eval       (cmp_eval),
        .step       (step)
    );

    bb_sat_counter #(.DUTY_W(DUTY_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .init_val (init_duty),
        .step     (step),
        .value    (duty)
    );
endmodule

// File: rtl/bb_duty_loop_chk.sv
module bb_duty_loop_chk #(
    parameter int DUTY_W = 10,
    parameter int SET_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              loop_en,
    input logic [SET_W-1:0]  settle_cyc,
    input logic              cmp_low,
    input logic              cmp_eval,
    input logic [DUTY_W-1:0] duty
);
    localparam logic [DUTY_W-1:0] TOP = '1;
    localparam logic [DUTY_W-1:0] BOT = '0;

    logic [SET_W:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst || !cmp_eval) begin
            wcnt <= '0;
        end else begin
            wcnt <= wcnt + (SET_W+1)'(1);
        end
    end

    // R5
    duty_moves_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty) |-> $fell(cmp_eval));

    // R6
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmp_eval) && $past(cmp_low) && $past(duty) != TOP)
            |-> duty == $past(duty) + DUTY_W'(1));

    // R6
    step_dn_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmp_eval) && !$past(cmp_low) && $past(duty) != BOT)
            |-> duty == $past(duty) - DUTY_W'(1));

    // R7
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmp_eval) && $past(cmp_low) && $past(duty) == TOP) |-> duty == TOP);

    // R7
    sat_bot_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cmp_eval) && !$past(cmp_low) && $past(duty) == BOT) |-> duty == BOT);

    // R2
    no_strobe_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!loop_en && !cmp_eval) |=> !cmp_eval);

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cmp_eval) |-> wcnt == {1'b0, $past(settle_cyc)} + (SET_W+1)'(1));
endmodule

bind bb_duty_loop bb_duty_loop_chk #(.DUTY_W(DUTY_W), .SET_W(SET_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .loop_en    (loop_en),
    .settle_cyc (settle_cyc),
    .cmp_low    (cmp_low),
    .cmp_eval   (cmp_eval),
    .duty       (duty)
);

// File: tb/test_bb_duty_loop.sv
module test_bb_duty_loop;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loop_en = 1'b0;
    logic [11:0] prescale = 12'd4;
    logic [5:0]  settle_cyc = 6'd2;
    logic [9:0]  init_duty = 10'd0;
    logic        cmp_low = 1'b0;
    logic        cmp_eval;
    logic [9:0]  duty;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bb_duty_loop i_bb_duty_loop (
        .clk(clk), .rst(rst), .loop_en(loop_en), .prescale(prescale),
        .settle_cyc(settle_cyc), .init_duty(init_duty), .cmp_low(cmp_low),
        .cmp_eval(cmp_eval), .duty(duty)
    );

    // {init[28:19], up[18], windows[17:10], expected[9:0]}
    localparam logic [28:0] VEC [6] = '{
        {10'd512,  1'b1, 8'd5, 10'd517},
        {10'd512,  1'b0, 8'd5, 10'd507},
        {10'd1020, 1'b1, 8'd8, 10'd1023},
        {10'd3,    1'b0, 8'd8, 10'd0},
        {10'd0,    1'b1, 8'd1, 10'd1},
        {10'd1023, 1'b0, 8'd1, 10'd1022}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [9:0] v);
        loop_en = 1'b0;
        rst = 1'b1;
        init_duty = v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_windows(input int n);
        repeat (n) begin
            while (cmp_eval !== 1'b1) @(negedge clk);
            while (cmp_eval === 1'b1) @(negedge clk);
        end
    endtask

    initial begin
        int w;
        int p;
        int d0;
        bit seen;

        @(negedge clk);
        // R1: reset state
        apply_reset(10'd300);
        check("R1 duty", duty, 300);
        check("R1 eval", cmp_eval, 0);

        // R6 R7: vector table
        for (int i = 0; i < 6; i++) begin
            apply_reset(VEC[i][28:19]);
            prescale = 12'd4;
            settle_cyc = 6'd2;
            cmp_low = VEC[i][18];
            loop_en = 1'b1;
            run_windows(int'(VEC[i][17:10]));
            loop_en = 1'b0;
            check("R6/R7 vector", duty, int'(VEC[i][9:0]));
        end

        // R2: disabled loop ignores comparator
        apply_reset(10'd700);
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            cmp_low = k[0];
            @(negedge clk);
            if (cmp_eval) seen = 1;
        end
        check("R2 strobe", int'(seen), 0);
        check("R2 duty", duty, 700);

        // R3 R4: width and spacing
        apply_reset(10'd400);
        prescale = 12'd9;
        settle_cyc = 6'd3;
        cmp_low = 1'b1;
        loop_en = 1'b1;
        while (!cmp_eval) @(negedge clk);
        w = 0;
        while (cmp_eval) begin w++; @(negedge clk); end
        p = w;
        while (!cmp_eval) begin p++; @(negedge clk); end
        check("R4 width", w, 4);
        check("R3 period", p, 10);
        loop_en = 1'b0;

        // R5: verdict taken on final strobe cycle only
        apply_reset(10'd600);
        prescale = 12'd9;
        settle_cyc = 6'd3;
        cmp_low = 1'b0;
        loop_en = 1'b1;
        while (!cmp_eval) @(negedge clk);
        d0 = duty;
        repeat (3) @(negedge clk);
        cmp_low = 1'b1;
        @(negedge clk);
        check("R5 eval low", cmp_eval, 0);
        check("R5 up on last", duty, d0 + 1);
        while (!cmp_eval) @(negedge clk);
        d0 = duty;
        repeat (3) @(negedge clk);
        cmp_low = 1'b0;
        @(negedge clk);
        check("R5 down on last", duty, d0 - 1);
        loop_en = 1'b0;

        // R8: ticks inside an open strobe are dropped
        apply_reset(10'd100);
        prescale = 12'd2;
        settle_cyc = 6'd5;
        cmp_low = 1'b1;
        loop_en = 1'b1;
        while (!cmp_eval) @(negedge clk);
        d0 = duty;
        p = 0;
        while (cmp_eval) begin p++; @(negedge clk); end
        check("R8 one step", duty, d0 + 1);
        while (!cmp_eval) begin p++; @(negedge clk); end
        check("R8 period", p, 9);
        loop_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule